// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

The aggregator merges level-sensitive interrupt requests from a set of device slots onto a few shared interrupt lines. Each slot has four request pins. Every pin is steered to one shared line by a fixed rotation: the pin number is added to the slot number and the sum is taken modulo the line count. As a result, neighbouring slots spread their first pin across different lines.

Each line is not an OR gate. It holds a counter of the sources currently asserting it. For every pin the block remembers the last level it sampled. A pin that moves from low to high adds one to its line's counter, and a pin that moves from high to low subtracts one. A pin that keeps its level changes nothing. A line is driven high whenever its counter is non-zero. All changes sampled in one clock are summed into each counter in that same clock, and the line output is a register.

Each pin's remembered level is a two-state machine:
- `PIN_IDLE` moves to `PIN_ASSERTED` on the RAISE transition, when the sampled level is 1. That transition emits a +1 for the pin's line.
- `PIN_ASSERTED` moves back to `PIN_IDLE` on the DROP transition, when the sampled level is 0. That transition emits a −1.
- In every other case the state holds and nothing is emitted.

A synchronous bus reset returns every pin machine to `PIN_IDLE` and every counter to zero.

Top module: `irq_line_aggregator`

## Requirements
- R1: Pin `p` (0 to 3) of slot `s` (0 to 31) is sampled from `pin_level[s*4 + p]`.
- R2: That pin is routed to shared line `(s + p) mod 4`, which is bit `(s + p) mod 4` of `line_out`.
- R3: Outside of reset, each line's counter equals the number of its routed pins whose remembered level is 1. `line_out[l]` is 1 exactly when counter `l` is non-zero.
- R4: A pin sampled at the same level as its remembered level changes no counter. A held input pattern keeps `line_out` constant.
- R5: A line shared by several asserted pins stays high until the last of them drops.
- R6: Several pin changes sampled in one clock are all applied to the counters in that clock. A rise and a fall on the same line in the same clock leave that line high.
- R7: While `bus_rst` is 1 at a clock edge, all counters, all remembered levels and `line_out` clear to 0. Pins still high when `bus_rst` returns to 0 are counted as new rises at the next edge.
- R8: A level change present at clock edge k is visible on `line_out` right after edge k, and not before that edge.
- R9: Every counter holds its worst case without overflow. This is all 32 pins routed to one line asserted together. Dropping them one group at a time keeps the line high until the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| bus_rst | input | 1 | Synchronous active-high bus reset clearing counters and remembered levels |
| pin_level | input | 128 | Request levels, pin `p` of slot `s` at bit `s*4+p` |
| line_out | output | 4 | Registered shared interrupt lines |

## Verification
Each pin is first raised alone, a walk over all 128 bits. This separates a wrong routing or index order from a correct one. Patterns that make several pins share a line, with the pins dropped one at a time and also swapped within one clock, separate a counter from a plain OR and expose a change that is lost when it shares a clock with another. Raising all 32 pins routed to one line stresses the counter width. A reset applied while pins are held high shows whether the remembered levels were cleared together with the counters: they must be, or the held pins would never be counted again.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Remembered level of one request pin.
    typedef enum logic {
        PIN_IDLE     = 1'b0,
        PIN_ASSERTED = 1'b1
    } pin_state_e;

    // Counter contribution produced by one pin in one cycle.
    typedef struct packed {
        logic rise;
        logic fall;
    } pin_delta_t;

endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       bus_rst,
    input  logic       level_i,
    output pin_delta_t delta_o
);

    pin_state_e st_q;
    pin_state_e st_d;

    // State register.
    always_ff @(posedge clk) begin
        if (bus_rst) begin
            st_q <= PIN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: RAISE and DROP transitions.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_IDLE:     if (level_i)  st_d = PIN_ASSERTED;
            PIN_ASSERTED: if (!level_i) st_d = PIN_IDLE;
        endcase
    end

    // Outputs: one signed step per real level change.
    always_comb begin
        delta_o = '0;
        unique case (st_q)
            PIN_IDLE:     delta_o.rise = level_i;
            PIN_ASSERTED: delta_o.fall = ~level_i;
        endcase
    end

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
    parameter int NUM_SLOTS     = 32,
    parameter int PINS_PER_SLOT = 4,
    parameter int NUM_LINES     = 4,
    parameter int CNT_W         = 6
) (
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] rise_i,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] fall_i,
    output logic [NUM_LINES-1:0][CNT_W-1:0]    up_o,
    output logic [NUM_LINES-1:0][CNT_W-1:0]    dn_o
);

    // Adds up, for every line, the rises and falls of the pins that the
    // rotation (slot + pin) mod NUM_LINES steers onto it.
    always_comb begin
        for (int l = 0; l < NUM_LINES; l++) begin
            up_o[l] = '0;
            dn_o[l] = '0;
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < PINS_PER_SLOT; p++) begin
                for (int l = 0; l < NUM_LINES; l++) begin
                    if (((s + p) % NUM_LINES) == l) begin
                        up_o[l] = up_o[l] + CNT_W'(rise_i[s*PINS_PER_SLOT + p]);
                        dn_o[l] = dn_o[l] + CNT_W'(fall_i[s*PINS_PER_SLOT + p]);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             bus_rst,
    input  logic [CNT_W-1:0] up_i,
    input  logic [CNT_W-1:0] dn_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             line_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             line_q;

    assign cnt_d = cnt_q + up_i - dn_i;

    always_ff @(posedge clk) begin
        if (bus_rst) begin
            cnt_q  <= '0;
            line_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            line_q <= (cnt_d != '0);
        end
    end

    assign cnt_o  = cnt_q;
    assign line_o = line_q;

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SLOTS     = 32,
    parameter int PINS_PER_SLOT = 4,
    parameter int NUM_LINES     = 4
) (
    input  logic                               clk,
    input  logic                               bus_rst,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_level,
    output logic [NUM_LINES-1:0]               line_out
);

    localparam int NUM_SRC      = NUM_SLOTS * PINS_PER_SLOT;
    localparam int PINS_PER_HIT = (PINS_PER_SLOT + NUM_LINES - 1) / NUM_LINES;
    localparam int MAX_PER_LINE = NUM_SLOTS * PINS_PER_HIT;
    localparam int CNT_W        = $clog2(MAX_PER_LINE + 1);

    logic [NUM_SRC-1:0]                 rise;
    logic [NUM_SRC-1:0]                 fall;
    logic [NUM_LINES-1:0][CNT_W-1:0]    up_cnt;
    logic [NUM_LINES-1:0][CNT_W-1:0]    dn_cnt;
    logic [NUM_LINES-1:0][CNT_W-1:0]    line_cnt;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pin
        pin_delta_t d;
        irq_pin_tracker u_trk (
            .clk     (clk),
            .bus_rst (bus_rst),
            .level_i (pin_level[i]),
            .delta_o (d)
        );
        assign rise[i] = d.rise;
        assign fall[i] = d.fall;
    end

    irq_line_router #(
        .NUM_SLOTS     (NUM_SLOTS),
        .PINS_PER_SLOT (PINS_PER_SLOT),
        .NUM_LINES     (NUM_LINES),
        .CNT_W         (CNT_W)
    ) u_route (
        .rise_i (rise),
        .fall_i (fall),
        .up_o   (up_cnt),
        .dn_o   (dn_cnt)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        irq_line_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .bus_rst (bus_rst),
            .up_i    (up_cnt[l]),
            .dn_i    (dn_cnt[l]),
            .cnt_o   (line_cnt[l]),
            .line_o  (line_out[l])
        );
    end

endmodule

// File: rtl/irq_line_aggregator_chk.sv
module irq_line_aggregator_chk #(
    parameter int NUM_SLOTS     = 32,
    parameter int PINS_PER_SLOT = 4,
    parameter int NUM_LINES     = 4,
    parameter int CNT_W         = 6,
    parameter int MAX_PER_LINE  = 32
) (
    input logic                               clk,
    input logic                               bus_rst,
    input logic [NUM_SLOTS*PINS_PER_SLOT-1:0] pin_level,
    input logic [NUM_LINES-1:0]               line_out,
    input logic [NUM_LINES-1:0][CNT_W-1:0]    line_cnt
);

    // Whether any input pin steered to each line is currently high.
    logic [NUM_LINES-1:0] any_routed;
    always_comb begin
        any_routed = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < PINS_PER_SLOT; p++) begin
                if (pin_level[s*PINS_PER_SLOT + p]) begin
                    any_routed[(s + p) % NUM_LINES] = 1'b1;
                end
            end
        end
    end

    // R7: the cycle after a bus reset edge all lines are low.
    p_reset_clears_r7: assert property (@(posedge clk) disable iff (bus_rst)
        $past(bus_rst) |-> (line_out == '0));

    // R4: held inputs leave the lines unchanged.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (bus_rst)
        ($stable(pin_level) && !$past(bus_rst)) |=> $stable(line_out));

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
        // R3 and R8: a line follows the routed levels sampled one edge earlier.
        p_line_level_r3: assert property (@(posedge clk) disable iff (bus_rst)
            !$past(bus_rst) |-> (line_out[l] == $past(any_routed[l])));

        // R9: no counter runs past the number of pins that can reach it.
        p_no_overflow_r9: assert property (@(posedge clk) disable iff (bus_rst)
            line_cnt[l] <= CNT_W'(MAX_PER_LINE));
    end

endmodule

bind irq_line_aggregator irq_line_aggregator_chk #(
    .NUM_SLOTS     (NUM_SLOTS),
    .PINS_PER_SLOT (PINS_PER_SLOT),
    .NUM_LINES     (NUM_LINES),
    .CNT_W         (CNT_W),
    .MAX_PER_LINE  (MAX_PER_LINE)
) u_chk (
    .clk       (clk),
    .bus_rst   (bus_rst),
    .pin_level (pin_level),
    .line_out  (line_out),
    .line_cnt  (line_cnt)
);

// File: tb/tb_irq_line_aggregator.sv
`timescale 1ns/1ps
module tb_irq_line_aggregator;

    localparam int NS   = 32;
    localparam int PP   = 4;
    localparam int NL   = 4;
    localparam int NSRC = NS * PP;

    logic            clk = 1'b0;
    logic            bus_rst = 1'b1;
    logic [NSRC-1:0] pin_level = '0;
    logic [NL-1:0]   line_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_line_aggregator dut (
        .clk       (clk),
        .bus_rst   (bus_rst),
        .pin_level (pin_level),
        .line_out  (line_out)
    );

    function automatic int idx(input int s, input int p);
        return s * PP + p;
    endfunction

    // Expected lines: a line is high when any pin routed to it is high.
    function automatic logic [NL-1:0] expect_or(input logic [NSRC-1:0] v);
        logic [NL-1:0] r = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < PP; p++)
                if (v[idx(s, p)]) r[(s + p) % NL] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input logic [NL-1:0] exp);
        checks++;
        if (line_out !== exp) begin
            errors++;
            $display("FAIL %s: actual line_out=%b expected=%b", tag, line_out, exp);
        end
    endtask

    // Called at a falling edge; applies v and returns one falling edge later.
    task automatic drive(input logic [NSRC-1:0] v);
        pin_level = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        bus_rst = 1'b1;
        repeat (3) @(negedge clk);
        bus_rst = 1'b0;
        @(negedge clk);
        check("R7 reset state", '0);
    endtask

    task automatic t_walk();
        for (int i = 0; i < NSRC; i++) begin
            logic [NSRC-1:0] v = '0;
            v[i] = 1'b1;
            drive(v);
            check($sformatf("R1 R2 pin bit %0d", i), NL'(1) << (((i / PP) + (i % PP)) % NL));
            drive('0);
            check("R2 walk release", '0);
        end
    endtask

    task automatic t_latency();
        logic [NSRC-1:0] v = '0;
        v[idx(5, 1)] = 1'b1;
        pin_level = v;
        #2;
        check("R8 before edge", '0);
        @(negedge clk);
        check("R8 after edge", 4'b0100);
        drive('0);
        check("R8 release", '0);
    endtask

    task automatic t_shared();
        logic [NSRC-1:0] a = '0;
        logic [NSRC-1:0] b = '0;
        a[idx(0, 0)] = 1'b1;
        b[idx(1, 3)] = 1'b1;
        drive(a | b);
        check("R5 two on line0", 4'b0001);
        drive(b);
        check("R5 one left", 4'b0001);
        drive('0);
        check("R5 last dropped", '0);
    endtask

    task automatic t_simul();
        logic [NSRC-1:0] a = '0;
        logic [NSRC-1:0] c = '0;
        logic [NSRC-1:0] e = '0;
        a[idx(0, 0)] = 1'b1;
        c[idx(2, 2)] = 1'b1;
        e[idx(0, 1)] = 1'b1;
        drive(a);
        check("R6 setup", 4'b0001);
        drive(c);
        check("R6 swap same line", 4'b0001);
        drive(a | c);
        check("R6 second joins", 4'b0001);
        drive('0);
        check("R6 both drop together", '0);
        drive(a);
        drive(e);
        check("R6 move line0 to line1", 4'b0010);
        drive('0);
        check("R6 release", '0);
    endtask

    task automatic t_hold();
        logic [NSRC-1:0] v = {4{32'h0000_1248}};
        for (int k = 0; k < 4; k++) begin
            drive(v);
            check("R4 held pattern", expect_or(v));
        end
        drive('0);
    endtask

    task automatic t_full_line();
        logic [NSRC-1:0] v = '0;
        logic [NSRC-1:0] last = '0;
        for (int s = 0; s < NS; s++) v[idx(s, (NL - (s % NL)) % NL)] = 1'b1;
        drive(v);
        check("R9 all 32 on line0", 4'b0001);
        last[idx(31, 1)] = 1'b1;
        drive(v & ~last & {{(NSRC/2){1'b0}}, {(NSRC/2){1'b1}}} | last);
        check("R9 half dropped", 4'b0001);
        drive(last);
        check("R9 one left", 4'b0001);
        drive('0);
        check("R9 count reaches zero", '0);
        drive('1);
        check("R3 all pins", 4'b1111);
        drive('0);
        check("R3 all released", '0);
    endtask

    task automatic t_patterns();
        logic [NSRC-1:0] pats [4];
        pats[0] = {4{32'hA5A5_A5A5}};
        pats[1] = {32'h8000_0000, 64'h0, 32'h0000_0001};
        pats[2] = '0;
        for (int s = 0; s < NS; s++) if (s % 3 == 0) pats[2][idx(s, (NL + 3 - (s % NL)) % NL)] = 1'b1;
        pats[3] = {NSRC/8{8'h10}};
        foreach (pats[k]) begin
            drive(pats[k]);
            check($sformatf("R3 pattern %0d", k), expect_or(pats[k]));
        end
        drive('0);
        check("R3 patterns cleared", '0);
    endtask

    task automatic t_bus_reset();
        drive('1);
        check("R7 before reset", 4'b1111);
        bus_rst = 1'b1;
        @(negedge clk);
        check("R7 cleared while held", '0);
        bus_rst = 1'b0;
        @(negedge clk);
        check("R7 held pins recounted", 4'b1111);
        drive('0);
        check("R7 release after recount", '0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_walk();
        t_latency();
        t_shared();
        t_simul();
        t_hold();
        t_full_line();
        t_patterns();
        t_bus_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule